// File: doc/BRIEF.md
# Break Input Source Combiner

This block gathers the fault inputs of a PWM timer into one active-high break request. Two kinds of source feed it: an external fault pin and up to three comparator outputs. Each source passes through its own two-flop synchronizer. It is then tested against the sense that counts as active for it, and all enabled sources are ORed together. A final register drives the break request.

The block holds one 16-bit configuration register, written over a simple write strobe. The register gives every source an enable bit and a polarity bit. A polarity bit does not fix the sense on its own. It selects whether the source follows the timer's global break polarity or runs opposite to it. The lock level comes from a separate protection register. Once that level is non-zero, the configuration register no longer changes. The third comparator can be left out by a parameter, which turns its bits into reserved zeros.

Top module: `brk_src_combiner`

## Requirements
- R1: After reset the configuration register reads 0x0000 and `brk_req` is 0.
- R2: A source whose enable bit is 0 never raises `brk_req`, whatever its input level or polarity. Enables: bit 0 pin, bit 1 comparator 1, bit 2 comparator 2, bit 3 comparator 3.
- R3: `brk_req` is the OR of all enabled sources that are active.
- R4: With a source polarity bit of 0, the source is active when its input level equals `brk_pol`. With `brk_pol`=0 it is active low; with `brk_pol`=1 it is active high. Polarity bits: bit 8 pin, bit 9 comparator 1, bit 10 comparator 2, bit 11 comparator 3.
- R5: With a source polarity bit of 1, the source is active when its input level differs from `brk_pol`.
- R6: A write with `lock_lvl`=0 stores the written value, masked to the implemented bits, at the clock edge where `cfg_wr_en` is high. The stored value is readable on `cfg_rd_data` right after that edge.
- R7: A write with `lock_lvl` equal to 1, 2 or 3 leaves the configuration register unchanged.
- R8: Bits 7:4 and 15:12 are reserved. They read 0, and writing ones to them has no effect.
- R9: With `HAS_CMP3`=0, bits 3 and 11 read 0 and comparator 3 never raises `brk_req`.
- R10: A change on a source input reaches `brk_req` after exactly three clock edges. A change of `brk_pol` or of the configuration reaches it after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Configuration register contents |
| lock_lvl | input | 2 | Write-protection level; any non-zero value locks the register |
| brk_pol | input | 1 | Global break polarity |
| pin_in | input | 1 | External fault pin, asynchronous |
| cmp_in | input | 3 | Comparator outputs 1 to 3, asynchronous |
| brk_req | output | 1 | Registered active-high break request |

## Verification
The bench tries to write at every non-zero lock level. A design that decoded only level 1 as locked would let the level 2 and 3 writes through. It writes all ones, so reserved bits that were stored would show up in the read-back. It sweeps both source polarities against both global polarities; an absolute polarity decode would fail half of those cases. It also counts edges after a single pin toggle and after a global polarity flip, so a missing or extra pipeline stage is caught. A second instance built without comparator 3 has to ignore that comparator's bits and its input.

// File: rtl/brk_src_combiner.sv
module brk_src_combiner #(
  parameter bit HAS_CMP3 = 1'b1,
  parameter int CFG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic [1:0]       lock_lvl,
  input  logic             brk_pol,
  input  logic             pin_in,
  input  logic [2:0]       cmp_in,
  output logic             brk_req
);
  localparam int NSRC = 4;
  localparam int POL_LSB = 8;
  localparam logic [NSRC-1:0] SRC_MASK = HAS_CMP3 ? 4'hF : 4'h7;
  localparam logic [CFG_W-1:0] WR_MASK =
    CFG_W'((32'(SRC_MASK) << POL_LSB) | 32'(SRC_MASK));

  logic [CFG_W-1:0] cfg_q;
  logic [NSRC-1:0]  sync1, sync2, hit;
  logic             wr_ok;

  assign wr_ok = cfg_wr_en && (lock_lvl == 2'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else if (wr_ok) cfg_q <= cfg_wr_data & WR_MASK;

  assign cfg_rd_data = cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {cmp_in, pin_in};
      sync2 <= sync1;
    end

  assign hit = cfg_q[NSRC-1:0] &
               ~(sync2 ^ cfg_q[POL_LSB +: NSRC] ^ {NSRC{brk_pol}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) brk_req <= 1'b0;
    else brk_req <= |hit;

  // R7: locked level freezes the register
  a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl != 2'd0) |=> $stable(cfg_rd_data));

  // R6: unlocked write lands masked
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && lock_lvl == 2'd0) |=> (cfg_rd_data == ($past(cfg_wr_data) & WR_MASK)));

  // R6: register changes only through an unlocked write
  a_r6_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rd_data) |-> $past(cfg_wr_en && lock_lvl == 2'd0));

  // R2: nothing enabled, no request next cycle
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[NSRC-1:0] == '0) |=> !brk_req);
endmodule

// File: tb/brk_src_combiner_bench.sv
module brk_src_combiner_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [1:0]  lock_lvl = 2'd0;
  logic        brk_pol = 1'b0;
  logic        pin_in = 1'b0;
  logic [2:0]  cmp_in = '0;
  logic [15:0] cfg_rd_data, nc_rd_data;
  logic        brk_req, nc_brk_req;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_src_combiner u_brk_src_combiner (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_data, .cfg_rd_data, .lock_lvl,
    .brk_pol, .pin_in, .cmp_in, .brk_req);

  brk_src_combiner #(.HAS_CMP3(1'b0)) u_brk_src_combiner_nc3 (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_data, .cfg_rd_data(nc_rd_data),
    .lock_lvl, .brk_pol, .pin_in, .cmp_in, .brk_req(nc_brk_req));

  function automatic logic exp_req(logic [15:0] cfg, logic pol, logic [3:0] lvl);
    logic [3:0] act;
    for (int i = 0; i < 4; i++)
      act[i] = cfg[i] && (lvl[i] == (pol ^ cfg[8+i]));
    return |act;
  endfunction

  logic [3:0]  h1, h2;
  logic [15:0] m_cfg;
  logic        m_exp;
  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; m_cfg = '0; m_exp = 1'b0;
    end else begin
      m_exp = exp_req(m_cfg, brk_pol, h2);
      h2 = h1;
      h1 = {cmp_in, pin_in};
      if (cfg_wr_en && lock_lvl == 2'd0) m_cfg = cfg_wr_data & 16'h0F0F;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [15:0] d, logic [1:0] lv);
    cfg_wr_en = 1'b1; cfg_wr_data = d; lock_lvl = lv;
    step();
    cfg_wr_en = 1'b0; lock_lvl = 2'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    check("R1 reset cfg", cfg_rd_data, 16'h0000);
    check("R1 reset brk", {15'd0, brk_req}, 16'd0);
    rst_n = 1'b1;
    step(2);

    // R2: all disabled, sources active in every sense
    for (int p = 0; p < 2; p++) begin
      brk_pol = p[0]; pin_in = p[0]; cmp_in = {3{p[0]}};
      step(4);
      check("R2 disabled no request", {15'd0, brk_req}, 16'd0);
    end
    wr(16'h0E00, 2'd0);
    pin_in = 1'b0; brk_pol = 1'b0; step(4);
    check("R2 pin disabled despite inverted pol", {15'd0, brk_req}, 16'd0);

    // R6 write and R8 reserved bits
    wr(16'h0305, 2'd0);
    check("R6 write at level 0", cfg_rd_data, 16'h0305);
    wr(16'hFFFF, 2'd0);
    check("R8 reserved bits read zero", cfg_rd_data, 16'h0F0F);
    check("R9 no cmp3 bits", nc_rd_data, 16'h0707);

    // R7 locked levels
    for (int lv = 1; lv < 4; lv++) begin
      wr(16'h0000, lv[1:0]);
      check("R7 write rejected while locked", cfg_rd_data, 16'h0F0F);
    end
    wr(16'h0000, 2'd0);
    check("R6 unlock write clears", cfg_rd_data, 16'h0000);

    // R4: pin only, polarity bit 0
    wr(16'h0001, 2'd0);
    brk_pol = 1'b0; pin_in = 1'b0; step(4);
    check("R4 pol0 gpol0 low active", {15'd0, brk_req}, 16'd1);
    pin_in = 1'b1; step(4);
    check("R4 pol0 gpol0 high idle", {15'd0, brk_req}, 16'd0);
    brk_pol = 1'b1; step(4);
    check("R4 pol0 gpol1 high active", {15'd0, brk_req}, 16'd1);

    // R5: pin polarity bit 1
    wr(16'h0101, 2'd0);
    brk_pol = 1'b0; pin_in = 1'b1; step(4);
    check("R5 pol1 gpol0 high active", {15'd0, brk_req}, 16'd1);
    brk_pol = 1'b1; pin_in = 1'b0; step(4);
    check("R5 pol1 gpol1 low active", {15'd0, brk_req}, 16'd1);
    pin_in = 1'b1; step(4);
    check("R5 pol1 gpol1 high idle", {15'd0, brk_req}, 16'd0);

    // R3: OR of comparators 1 and 2, active high
    wr(16'h0006, 2'd0);
    brk_pol = 1'b1; pin_in = 1'b1; cmp_in = 3'b000; step(4);
    check("R3 none active", {15'd0, brk_req}, 16'd0);
    cmp_in = 3'b010; step(4);
    check("R3 cmp2 alone", {15'd0, brk_req}, 16'd1);
    cmp_in = 3'b001; step(4);
    check("R3 cmp1 alone", {15'd0, brk_req}, 16'd1);
    cmp_in = 3'b100; step(4);
    check("R3 disabled cmp3 ignored", {15'd0, brk_req}, 16'd0);

    // R9: cmp3 only
    wr(16'h0008, 2'd0);
    cmp_in = 3'b100; step(4);
    check("R9 cmp3 present raises", {15'd0, brk_req}, 16'd1);
    check("R9 cmp3 absent silent", {15'd0, nc_brk_req}, 16'd0);

    // R10 latency
    wr(16'h0001, 2'd0);
    brk_pol = 1'b1; pin_in = 1'b0; cmp_in = '0; step(5);
    pin_in = 1'b1;
    step(2);
    check("R10 two edges still old", {15'd0, brk_req}, 16'd0);
    step();
    check("R10 third edge new", {15'd0, brk_req}, 16'd1);
    brk_pol = 1'b0;
    step();
    check("R10 gpol change one edge", {15'd0, brk_req}, 16'd0);

    // random against model
    for (int i = 0; i < 4000; i++) begin
      pin_in = 1'($urandom);
      cmp_in = 3'($urandom);
      if ($urandom_range(0, 7) == 0) brk_pol = ~brk_pol;
      cfg_wr_en = ($urandom_range(0, 9) == 0);
      cfg_wr_data = 16'($urandom);
      lock_lvl = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom_range(1, 3));
      step();
      check("R3 random request", {15'd0, brk_req}, {15'd0, m_exp});
      check("R7 random cfg", cfg_rd_data, m_cfg);
    end
    cfg_wr_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule